// File: doc/BRIEF.md
# Flux Transition Timestamp Recorder

This block captures when a disk read-data line changes, measured against the index pulse. It then reproduces those changes with the same timing at the sample clock's resolution. A reference counter counts sample clocks and is cleared by each index edge. For every rising edge on the read-data line it keeps only the low four bits of that counter. The buffer therefore takes one narrow word per transition, where a sampled bitstream would need one bit per clock.

When `mode_play` is low, each synchronized rising edge of `rdata_in` appends the counter's low bits to an internal buffer. Each index edge starts the buffer over. When `mode_play` is high, the buffer is walked in order. Each time the next stored value equals the counter's low bits, `wdata_out` pulses for one clock and the walk moves on. An index edge restarts the walk from the first entry. The walk stops after the last recorded entry.

A value of four bits can only place a transition within 16 clocks of the previous one, or of the index. `gap_err` latches when a recording breaks that limit, or when a transition arrives with the buffer full.

Top module: `flux_stamp`

## Requirements
- R1: After reset, `wdata_out` and `gap_err` are 0 and the buffer holds no entries.
- R2: `rdata_in` and `index_in` each pass through two synchronizing flops and a rising-edge detector. The reference counter reads 0 in the clock after a synchronized index edge and then counts up by one per clock.
- R3: With `mode_play` = 0, each synchronized rising edge of `rdata_in` stores the counter's low 4 bits as the next buffer entry. A synchronized index edge empties the buffer before new entries are stored.
- R4: With `mode_play` = 1, `wdata_out` is a one-clock pulse per stored entry. If `rdata_in` rose k clocks after `index_in` rose while recording, the pulse rises k + 2 clocks after a playback `index_in` rise. This holds for every entry whose spacing is within the R7 limit.
- R5: Playback emits exactly as many pulses per revolution as entries were recorded, and nothing more until the next index edge restarts it from the first entry.
- R6: A read-data edge in the same clock as an index edge is discarded; it is not stored.
- R7: Recording raises sticky `gap_err` in two cases: the first transition lands more than 16 clocks after an index rise, or two consecutive transitions are more than 16 clocks apart. A spacing of exactly 16 is accepted. The check is armed by the first index edge after reset and is inactive in playback.
- R8: A recorded transition arriving with `DEPTH` entries already stored is dropped and sets `gap_err`.
- R9: In record mode `wdata_out` stays 0. In playback, edges on `rdata_in` do not change the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_play | input | 1 | 0 = record, 1 = playback |
| index_in | input | 1 | Index pulse, asynchronous |
| rdata_in | input | 1 | Read-data line, asynchronous |
| wdata_out | output | 1 | Regenerated transition pulse |
| gap_err | output | 1 | Sticky error: gap too long or buffer overflow |

## Verification
The single-clock-pulse property only holds when consecutive stored stamps are at least two and at most sixteen clocks apart. A larger gap aliases onto the next clock and gives back-to-back pulses. The stimulus therefore keeps recorded spacing between 2 and 16 in every revolution that is later played back. The one recording with a 17-clock gap is cleared by reset before the mode returns to playback. Mode changes are made only while the line is quiet, at least three clocks after the last rise, so no edge is still in flight through the synchronizer.

// File: rtl/flux_stamp.sv
module flux_stamp #(
  parameter int CNT_W = 20,
  parameter int TAG_W = 4,
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_play,
  input  logic index_in,
  input  logic rdata_in,
  output logic wdata_out,
  output logic gap_err
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] LAST = (PTR_W + 1)'(DEPTH);
  localparam logic [TAG_W:0] GAP_LIM = (TAG_W + 1)'(2 ** TAG_W);

  logic [2:0] rd_s, ix_s;
  logic [CNT_W-1:0] ref_cnt;
  logic [PTR_W:0] wptr, rptr;
  logic [TAG_W:0] gap_cnt;
  logic armed;
  logic [TAG_W-1:0] mem [DEPTH];

  wire rd_edge = rd_s[1] & ~rd_s[2];
  wire idx_edge = ix_s[1] & ~ix_s[2];
  wire [TAG_W-1:0] tag_now = ref_cnt[TAG_W-1:0];
  wire full = (wptr == LAST);
  wire store = rd_edge & ~idx_edge & ~mode_play;
  wire gap_over = armed & ~mode_play & (gap_cnt == GAP_LIM);
  wire hit = mode_play & ~idx_edge & (rptr < wptr) & (mem[rptr[PTR_W-1:0]] == tag_now);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_s <= '0;
      ix_s <= '0;
    end else begin
      rd_s <= {rd_s[1:0], rdata_in};
      ix_s <= {ix_s[1:0], index_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ref_cnt <= '0;
    else if (idx_edge) ref_cnt <= '0;
    else ref_cnt <= ref_cnt + 1'b1;

  always_ff @(posedge clk)
    if (store && !full) mem[wptr[PTR_W-1:0]] <= tag_now;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wptr <= '0;
    else if (idx_edge && !mode_play) wptr <= '0;
    else if (store && !full) wptr <= wptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rptr <= '0;
    else if (idx_edge) rptr <= '0;
    else if (hit) rptr <= rptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gap_cnt <= '0;
    else if (mode_play || idx_edge || rd_edge) gap_cnt <= '0;
    else if (gap_cnt != GAP_LIM) gap_cnt <= gap_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      gap_err <= 1'b0;
      wdata_out <= 1'b0;
    end else begin
      armed <= armed | idx_edge;
      gap_err <= gap_err | gap_over | (store & full);
      wdata_out <= hit;
    end

  AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (!rst_n) wdata_out |=> !wdata_out); // R4
  AST_RECORD_SILENT: assert property (@(posedge clk) disable iff (!rst_n) !mode_play |=> !wdata_out); // R9
  AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rptr <= wptr); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) gap_err |=> gap_err); // R7
  AST_WPTR_CAP: assert property (@(posedge clk) disable iff (!rst_n) wptr <= LAST); // R8
  AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (store && full) |=> gap_err); // R8
endmodule

// File: tb/flux_stamp_test.sv
module flux_stamp_test;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0, mode_play = 1, index_in = 0, rdata_in = 0;
  logic wdata_out, gap_err;
  int checks = 0, fails = 0, pulses = 0;

  flux_stamp #(.CNT_W(20), .TAG_W(4), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .mode_play(mode_play), .index_in(index_in),
    .rdata_in(rdata_in), .wdata_out(wdata_out), .gap_err(gap_err));

  always #4 clk = ~clk;

  // behavioural reference model
  int stamps[$];
  int m_ref, rpos, gap;
  bit m_rd1, m_rd2, m_rd3, m_ix1, m_ix2, m_ix3, armed, e_err, e_out;
  bit redge, iedge, hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamps.delete();
      m_ref = 0; rpos = 0; gap = 0; armed = 0; e_err = 0; e_out = 0;
      {m_rd1, m_rd2, m_rd3, m_ix1, m_ix2, m_ix3} = '0;
    end else begin
      redge = m_rd2 && !m_rd3;
      iedge = m_ix2 && !m_ix3;
      hit = mode_play && !iedge && rpos < stamps.size() && (stamps[rpos] % 16) == (m_ref % 16);
      if (armed && !mode_play && gap == 16) e_err = 1;
      if (!mode_play && !iedge && redge) begin
        if (stamps.size() < DEPTH) stamps.push_back(m_ref);
        else e_err = 1;
      end
      if (!mode_play && iedge) stamps.delete();
      if (mode_play || iedge || redge) gap = 0;
      else if (gap < 16) gap = gap + 1;
      if (iedge) rpos = 0;
      else if (hit) rpos = rpos + 1;
      armed = armed | iedge;
      m_ref = iedge ? 0 : (m_ref + 1) % (1 << 20);
      e_out = hit;
      m_rd3 = m_rd2; m_rd2 = m_rd1; m_rd1 = rdata_in;
      m_ix3 = m_ix2; m_ix2 = m_ix1; m_ix1 = index_in;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R2 R3 R4 R6 R9 wdata_out vs model", {31'd0, wdata_out}, {31'd0, e_out});
    check("R7 R8 gap_err vs model", {31'd0, gap_err}, {31'd0, e_err});
    if (wdata_out) pulses++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; mode_play = 1; index_in = 0; rdata_in = 0;
    tick(3);
    rst_n = 1;
    tick(1);
  endtask

  task automatic rev(input int rises[$], input int extra);
    int last = rises.size() > 0 ? rises[rises.size()-1] : 0;
    for (int t = 0; t <= last + extra; t++) begin
      index_in = (t < 3);
      rdata_in = 0;
      if (rises.size() > 0 && rises[0] == t) begin
        rdata_in = 1;
        void'(rises.pop_front());
      end
      @(negedge clk);
    end
    index_in = 0; rdata_in = 0;
  endtask

  task automatic play_rev(input int len, input bit noise);
    for (int t = 0; t < len; t++) begin
      index_in = (t < 3);
      rdata_in = noise && (t % 4 == 1);
      @(negedge clk);
    end
    index_in = 0; rdata_in = 0;
    tick(4);
  endtask

  task automatic to_record();
    mode_play = 0;
    tick(2);
  endtask

  task automatic to_play();
    mode_play = 1;
    tick(300);
    pulses = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    check("R1 wdata_out after reset", {31'd0, wdata_out}, 0);
    check("R1 gap_err after reset", {31'd0, gap_err}, 0);
    tick(40);
    check("R1 no playback from empty buffer", pulses, 0);

    // FM-like spacing, including 2 and 16 clock gaps
    to_record();
    pulses = 0;
    rev('{6, 15, 25, 30, 39, 44, 54, 58, 67, 77, 79, 95, 98, 105}, 3);
    check("R9 no pulses while recording", pulses, 0);
    to_play();
    play_rev(150, 1);
    check("R3 R4 R9 pulses per revolution with noisy rdata", pulses, 14);
    pulses = 0;
    play_rev(150, 0);
    check("R5 second revolution replays again", pulses, 14);
    pulses = 0;
    tick(100);
    check("R5 no pulses after last entry", pulses, 0);
    check("R7 no error for legal gaps", {31'd0, gap_err}, 0);

    // transition coincident with index is dropped
    to_record();
    rev('{0, 5, 13, 25, 31}, 3);
    to_play();
    play_rev(80, 0);
    check("R6 coincident edge discarded", pulses, 4);

    // overflow
    do_reset();
    to_record();
    rev('{4, 8, 12, 16, 20, 24, 28, 32, 36, 40, 44, 48, 52, 56, 60, 64, 68, 72}, 3);
    check("R8 overflow sets gap_err", {31'd0, gap_err}, 1);
    to_play();
    play_rev(120, 0);
    check("R8 only DEPTH entries kept", pulses, DEPTH);
    check("R7 gap_err sticky", {31'd0, gap_err}, 1);

    // gap limit boundary
    do_reset();
    to_record();
    rev('{16, 32, 48}, 3);
    check("R7 gap of exactly 16 accepted", {31'd0, gap_err}, 0);
    to_record();
    rev('{10, 27}, 3);
    check("R7 gap of 17 flagged", {31'd0, gap_err}, 1);
    do_reset();
    check("R1 reset clears gap_err", {31'd0, gap_err}, 0);
    tick(5);
    summary();
  end
endmodule